// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache with Run-Time Modes

This block sits between a processor load/store port and a slower word-wide external memory. It keeps recently used 128-byte lines in a 4-way set-associative store and holds written data on chip until a line must leave. A two-bit mode input selects normal caching, a frozen state in which resident lines still serve hits but nothing new is allocated, or a bypass state in which every access goes straight to memory and the stored lines are left untouched. A 256-bit map, one bit for each 16 MB region, marks which address regions may be cached at all.

Software keeps the cache coherent with other masters through range maintenance commands: given a start address and a byte count, the block can discard the lines in the range, write dirty lines in the range back to memory, or do both. The requester waits on a completion flag. While a line fill, an eviction or a maintenance command runs, the processor port is stalled through its ready/valid handshake.

Top module: `wbcache`

## Requirements
- R1: While reset is held, `mntDone` is 1 and `cpuReady` and `memReq` are 0; after reset every line is invalid, so the first cacheable read misses.
- R2: A cacheable read miss in normal mode (`mode` = 2'b00) reads the whole 128-byte line as 32 word beats from memory and then completes with the memory value; a hit completes in the cycle the request is presented, with no memory traffic.
- R3: A write that hits updates the cache only and makes no memory write; a later read returns the written value.
- R4: Each set has 4 ways; a miss fills an invalid way before it evicts any valid way, otherwise it evicts the least recently used way, and a dirty victim is written back as 32 word beats before the fill.
- R5: In freeze mode (`mode` = 2'b01) hits behave as in normal mode; a miss makes a single word access to memory and changes no line, so repeating it misses again.
- R6: In bypass mode (`mode` = 2'b10 or 2'b11) every access is a single word access to memory, and the stored lines and their dirty data are neither read nor changed.
- R7: An access whose region bit `cacheMap[addr[31:24]]` is 0 is never cached and always goes to memory as a single word access.
- R8: Command code 2'b01 clears the valid bit of every resident line overlapping the range and writes nothing back, even for dirty lines.
- R9: Command code 2'b10 writes every dirty resident line overlapping the range to memory and marks it clean; the line stays resident, and repeating the command writes nothing.
- R10: Command code 2'b11 writes back dirty lines in the range and then invalidates every resident line in the range.
- R11: The range is widened to whole lines: the start is rounded down and start plus count rounded up to 128-byte boundaries; a count of 0 touches no line.
- R12: `mntReady` is high only when no command is running; `mntDone` is low from the cycle after acceptance until the command has finished, and the processor port gets no response meanwhile.
- R13: Once raised, `memReq` stays high with a stable address and direction until `memAck` is seen.
- R14: `cpuReady` is only raised while `cpuValid` is high, and the request inputs must stay stable until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 normal, 01 freeze, 1x bypass |
| cacheMap | input | 256 | Cacheable bit for each 16 MB region |
| cpuValid | input | 1 | Processor request valid |
| cpuWrite | input | 1 | 1 for a store, 0 for a load |
| cpuAddr | input | 32 | Byte address (word aligned use) |
| cpuWdata | input | 32 | Store data |
| cpuReady | output | 1 | Request completes this cycle |
| cpuRdata | output | 32 | Load data, valid with cpuReady |
| mntValid | input | 1 | Maintenance command request |
| mntOp | input | 2 | bit1 write back dirty, bit0 invalidate |
| mntStart | input | 32 | Range start byte address |
| mntCount | input | 32 | Range length in bytes |
| mntReady | output | 1 | Command accepted when high with mntValid |
| mntDone | output | 1 | No command in progress |
| memReq | output | 1 | External word access request |
| memWe | output | 1 | External access is a write |
| memAddr | output | 32 | External word address |
| memWdata | output | 32 | External write data |
| memAck | input | 1 | External access completes |
| memRdata | input | 32 | External read data, valid with memAck |

## Verification
A hit answers in the same cycle the request is presented, so the bench samples `cpuReady` one nanosecond after the negative edge on which it raised `cpuValid` and counts zero waited cycles for every hit. Misses, uncached accesses and evictions take a data-dependent number of memory beats, so the bench polls `cpuReady` at each negative edge and judges them by the beat counts its memory model records (32 reads per fill, 32 writes per dirty eviction, one beat per direct access). A maintenance command must drop `mntDone` and `mntReady` by the cycle after acceptance, which the bench samples right after that edge; it then polls for `mntDone` before looking at memory contents and traffic.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int WAYS       = 4;
  localparam int WAY_W      = $clog2(WAYS);
  localparam int LINE_BYTES = 128;
  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int LINE_WORDS = LINE_BYTES / (DATA_W / 8);
  localparam int WIDX_W     = $clog2(LINE_WORDS);
  localparam int REGION_LSB = 24;

  typedef enum logic [2:0] {
    S_IDLE, S_DIRECT, S_EVICT, S_FILL, S_MSCAN
  } ctlState_t;

  // strobes from control to the datapath
  typedef struct packed {
    logic touch;   // LRU update of the hit way in the looked-up set
    logic cpuWr;   // store word into the hit way, mark dirty
    logic fillWr;  // store a fill beat into the op way
    logic fillEnd; // mark op way valid/clean with new tag
    logic clean;   // clear dirty of op way
    logic inval;   // clear valid of op way
  } dpStrobe_t;
endpackage

// File: rtl/wbc_datapath.sv
module wbc_datapath import wbc_pkg::*; #(
  parameter int SETS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookAddr,
  input  dpStrobe_t         stb,
  input  logic [SET_W-1:0]  opSet,
  input  logic [WAY_W-1:0]  opWay,
  input  logic [WIDX_W-1:0] wordIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] fillData,
  output logic              hit,
  output logic [WAY_W-1:0]  hitWay,
  output logic              hitDirty,
  output logic [WAY_W-1:0]  victimWay,
  output logic              victimValid,
  output logic              victimDirty,
  output logic [TAG_W-1:0]  victimTag,
  output logic [DATA_W-1:0] rdWord,
  output logic [DATA_W-1:0] evWord
);
  logic [SETS-1:0][WAYS-1:0] validQ, dirtyQ;
  logic [TAG_W-1:0]  tagQ  [SETS][WAYS];
  logic [WAY_W-1:0]  ageQ  [SETS][WAYS];
  logic [DATA_W-1:0] dataQ [SETS][WAYS][LINE_WORDS];

  logic [SET_W-1:0]  lookSet;
  logic [TAG_W-1:0]  lookTag;
  logic [WIDX_W-1:0] lookWord;
  logic [WAYS-1:0]   wayMatch;

  assign lookSet  = lookAddr[OFF_W +: SET_W];
  assign lookTag  = lookAddr[ADDR_W-1 -: TAG_W];
  assign lookWord = lookAddr[2 +: WIDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayMatch[w] = validQ[lookSet][w] && (tagQ[lookSet][w] == lookTag);
  end

  always_comb begin
    hit = 1'b0;
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (wayMatch[w]) begin hit = 1'b1; hitWay = WAY_W'(w); end
  end

  // first invalid way wins, else the oldest way
  always_comb begin
    logic found;
    found = 1'b0;
    victimWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (!found && !validQ[lookSet][w]) begin victimWay = WAY_W'(w); found = 1'b1; end
    if (!found)
      for (int w = 0; w < WAYS; w++)
        if (ageQ[lookSet][w] == WAY_W'(WAYS-1)) victimWay = WAY_W'(w);
  end

  assign victimValid = validQ[lookSet][victimWay];
  assign victimDirty = dirtyQ[lookSet][victimWay];
  assign victimTag   = tagQ[lookSet][victimWay];
  assign hitDirty    = dirtyQ[lookSet][hitWay];
  assign rdWord      = dataQ[lookSet][hitWay][lookWord];
  assign evWord      = dataQ[opSet][opWay][wordIdx];

  logic             touchEn;
  logic [SET_W-1:0] touchSet;
  logic [WAY_W-1:0] touchWay;
  assign touchEn  = stb.touch | stb.fillEnd;
  assign touchSet = stb.fillEnd ? opSet : lookSet;
  assign touchWay = stb.fillEnd ? opWay : hitWay;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) ageQ[s][w] <= WAY_W'(w);
    end else begin
      if (stb.cpuWr) dirtyQ[lookSet][hitWay] <= 1'b1;
      if (stb.fillEnd) begin
        validQ[opSet][opWay] <= 1'b1;
        dirtyQ[opSet][opWay] <= 1'b0;
      end
      if (stb.clean) dirtyQ[opSet][opWay] <= 1'b0;
      if (stb.inval) validQ[opSet][opWay] <= 1'b0;
      if (touchEn) begin
        for (int w = 0; w < WAYS; w++)
          if (ageQ[touchSet][w] < ageQ[touchSet][touchWay])
            ageQ[touchSet][w] <= ageQ[touchSet][w] + 1'b1;
        ageQ[touchSet][touchWay] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.cpuWr)   dataQ[lookSet][hitWay][lookWord] <= wrData;
    if (stb.fillWr)  dataQ[opSet][opWay][wordIdx] <= fillData;
    if (stb.fillEnd) tagQ[opSet][opWay] <= lookTag;
  end
endmodule

// File: rtl/wbc_control.sv
module wbc_control import wbc_pkg::*; #(
  parameter int SETS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [255:0]      cacheMap,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic              mntValid,
  input  logic [1:0]        mntOp,
  input  logic [ADDR_W-1:0] mntStart,
  input  logic [ADDR_W-1:0] mntCount,
  output logic              mntReady,
  output logic              mntDone,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              hit,
  input  logic [WAY_W-1:0]  hitWay,
  input  logic              hitDirty,
  input  logic [WAY_W-1:0]  victimWay,
  input  logic              victimValid,
  input  logic              victimDirty,
  input  logic [TAG_W-1:0]  victimTag,
  input  logic [DATA_W-1:0] rdWord,
  input  logic [DATA_W-1:0] evWord,
  output dpStrobe_t         stb,
  output logic [ADDR_W-1:0] lookAddr,
  output logic [SET_W-1:0]  opSet,
  output logic [WAY_W-1:0]  opWay,
  output logic [WIDX_W-1:0] wordIdx
);
  localparam logic [ADDR_W:0] LINE_MASK = ~(ADDR_W+1)'(LINE_BYTES-1);

  ctlState_t         stateQ, nextState;
  logic [WIDX_W-1:0] wordQ;
  logic [SET_W-1:0]  opSetQ;
  logic [WAY_W-1:0]  opWayQ;
  logic [TAG_W-1:0]  evTagQ;
  logic              forMntQ, mntActiveQ;
  logic [1:0]        mntOpQ;
  logic [ADDR_W:0]   mntLineQ, mntEndQ;

  logic cacheable, acceptMnt, missStart, mntEvict, advance, finish, beat;
  logic [SET_W-1:0] lookSet;
  logic [TAG_W-1:0] lookTag;

  assign cacheable = cacheMap[cpuAddr[ADDR_W-1:REGION_LSB]] && !mode[1];
  assign lookAddr  = (stateQ == S_MSCAN) ? mntLineQ[ADDR_W-1:0] : cpuAddr;
  assign lookSet   = lookAddr[OFF_W +: SET_W];
  assign lookTag   = lookAddr[ADDR_W-1 -: TAG_W];
  assign opSet     = (stateQ == S_MSCAN) ? lookSet : opSetQ;
  assign opWay     = (stateQ == S_MSCAN) ? hitWay : opWayQ;
  assign wordIdx   = wordQ;
  assign mntReady  = (stateQ == S_IDLE);
  assign mntDone   = !mntActiveQ;

  always_comb begin
    stb = '0;
    cpuReady = 1'b0;
    cpuRdata = rdWord;
    memReq = 1'b0;
    memWe = 1'b0;
    memAddr = '0;
    memWdata = evWord;
    nextState = stateQ;
    {acceptMnt, missStart, mntEvict, advance, finish, beat} = '0;
    case (stateQ)
      S_IDLE:
        if (mntValid) begin
          acceptMnt = 1'b1;
          nextState = S_MSCAN;
        end else if (cpuValid) begin
          if (cacheable && hit) begin
            cpuReady  = 1'b1;
            stb.touch = 1'b1;
            stb.cpuWr = cpuWrite;
          end else if (cacheable && mode == 2'b00) begin
            missStart = 1'b1;
            nextState = (victimValid && victimDirty) ? S_EVICT : S_FILL;
          end else begin
            nextState = S_DIRECT;
          end
        end
      S_DIRECT: begin
        memReq   = 1'b1;
        memWe    = cpuWrite;
        memAddr  = {cpuAddr[ADDR_W-1:2], 2'b00};
        memWdata = cpuWdata;
        if (memAck) begin
          cpuReady  = 1'b1;
          cpuRdata  = memRdata;
          nextState = S_IDLE;
        end
      end
      S_EVICT: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        memAddr = {evTagQ, opSetQ, wordQ, 2'b00};
        if (memAck) begin
          beat = 1'b1;
          if (&wordQ) begin
            if (forMntQ) begin
              stb.clean = 1'b1;
              stb.inval = mntOpQ[0];
              advance   = 1'b1;
              nextState = S_MSCAN;
            end else begin
              nextState = S_FILL;
            end
          end
        end
      end
      S_FILL: begin
        memReq  = 1'b1;
        memAddr = {cpuAddr[ADDR_W-1:OFF_W], wordQ, 2'b00};
        if (memAck) begin
          beat = 1'b1;
          stb.fillWr = 1'b1;
          if (&wordQ) begin
            stb.fillEnd = 1'b1;
            nextState   = S_IDLE;
          end
        end
      end
      S_MSCAN:
        if (mntLineQ >= mntEndQ) begin
          finish    = 1'b1;
          nextState = S_IDLE;
        end else if (hit && mntOpQ[1] && hitDirty) begin
          mntEvict  = 1'b1;
          nextState = S_EVICT;
        end else begin
          stb.inval = hit && mntOpQ[0];
          advance   = 1'b1;
        end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= S_IDLE;
      wordQ      <= '0;
      opSetQ     <= '0;
      opWayQ     <= '0;
      evTagQ     <= '0;
      forMntQ    <= 1'b0;
      mntActiveQ <= 1'b0;
      mntOpQ     <= '0;
      mntLineQ   <= '0;
      mntEndQ    <= '0;
    end else begin
      stateQ <= nextState;
      if (beat) wordQ <= wordQ + 1'b1;
      if (missStart || mntEvict) begin
        opSetQ  <= lookSet;
        opWayQ  <= missStart ? victimWay : hitWay;
        evTagQ  <= missStart ? victimTag : lookTag;
        forMntQ <= mntEvict;
        wordQ   <= '0;
      end
      if (acceptMnt) begin
        mntLineQ   <= {1'b0, mntStart} & LINE_MASK;
        mntEndQ    <= (mntCount == '0) ? ({1'b0, mntStart} & LINE_MASK)
                    : (({1'b0, mntStart} + {1'b0, mntCount}
                        + (ADDR_W+1)'(LINE_BYTES-1)) & LINE_MASK);
        mntOpQ     <= mntOp;
        mntActiveQ <= 1'b1;
      end
      if (advance) mntLineQ <= mntLineQ + (ADDR_W+1)'(LINE_BYTES);
      if (finish)  mntActiveQ <= 1'b0;
    end
  end
endmodule

// File: rtl/wbcache.sv
module wbcache import wbc_pkg::*; #(
  parameter int SETS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   mode,
  input  logic [255:0] cacheMap,
  input  logic         cpuValid,
  input  logic         cpuWrite,
  input  logic [31:0]  cpuAddr,
  input  logic [31:0]  cpuWdata,
  output logic         cpuReady,
  output logic [31:0]  cpuRdata,
  input  logic         mntValid,
  input  logic [1:0]   mntOp,
  input  logic [31:0]  mntStart,
  input  logic [31:0]  mntCount,
  output logic         mntReady,
  output logic         mntDone,
  output logic         memReq,
  output logic         memWe,
  output logic [31:0]  memAddr,
  output logic [31:0]  memWdata,
  input  logic         memAck,
  input  logic [31:0]  memRdata
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;

  dpStrobe_t         stb;
  logic [31:0]       lookAddr, rdWord, evWord;
  logic [SET_W-1:0]  opSet;
  logic [WAY_W-1:0]  opWay, hitWay, victimWay;
  logic [WIDX_W-1:0] wordIdx;
  logic              hit, hitDirty, victimValid, victimDirty;
  logic [TAG_W-1:0]  victimTag;

  wbc_control #(.SETS(SETS)) u_ctl (
    .clk, .rstN, .mode, .cacheMap, .cpuValid, .cpuWrite, .cpuAddr, .cpuWdata,
    .cpuReady, .cpuRdata, .mntValid, .mntOp, .mntStart, .mntCount, .mntReady,
    .mntDone, .memReq, .memWe, .memAddr, .memWdata, .memAck, .memRdata,
    .hit, .hitWay, .hitDirty, .victimWay, .victimValid, .victimDirty,
    .victimTag, .rdWord, .evWord, .stb, .lookAddr, .opSet, .opWay, .wordIdx
  );

  wbc_datapath #(.SETS(SETS)) u_dp (
    .clk, .rstN, .lookAddr, .stb, .opSet, .opWay, .wordIdx,
    .wrData(cpuWdata), .fillData(memRdata), .hit, .hitWay, .hitDirty,
    .victimWay, .victimValid, .victimDirty, .victimTag, .rdWord, .evWord
  );
endmodule

// File: rtl/wbc_checker.sv
module wbc_checker (
  input logic         clk,
  input logic         rstN,
  input logic [1:0]   mode,
  input logic [255:0] cacheMap,
  input logic         cpuValid,
  input logic [31:0]  cpuAddr,
  input logic         cpuReady,
  input logic         mntReady,
  input logic         mntDone,
  input logic         memReq,
  input logic         memWe,
  input logic [31:0]  memAddr,
  input logic         memAck
);
  p_ready_valid_r14: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuValid);

  p_mem_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  p_stall_r12: assert property (@(posedge clk) disable iff (!rstN)
    !mntDone |-> !cpuReady);

  p_accept_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    mntReady |-> mntDone);

  p_done_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mntDone) |-> !memReq);

  p_bypass_mem_r6: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady && mode[1] |-> memAck);

  p_uncached_mem_r7: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady && !cacheMap[cpuAddr[31:24]] |-> memAck);
endmodule

bind wbcache wbc_checker u_chk (
  .clk, .rstN, .mode, .cacheMap, .cpuValid, .cpuAddr, .cpuReady,
  .mntReady, .mntDone, .memReq, .memWe, .memAddr, .memAck
);

// File: tb/tb_wbcache.sv
module tb_wbcache;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [255:0] cacheMap = '0;
  logic cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic cpuReady;
  logic [31:0] cpuRdata;
  logic mntValid = 1'b0;
  logic [1:0] mntOp = 2'b00;
  logic [31:0] mntStart = '0, mntCount = '0;
  logic mntReady, mntDone;
  logic memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic memAck;
  logic [31:0] memRdata;

  wbcache dut (.*);

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit finished = 1'b0;

  function automatic logic [31:0] seedVal(int i);
    return 32'(i) * 32'h9E3779B1 ^ 32'hA5A50000;
  endfunction
  function automatic int ix(logic [31:0] a);
    return int'({a[25:24], a[11:2]});
  endfunction

  // external memory model: ack on the third edge after a request
  logic [31:0] extMem [4096];
  int rdCnt, wrCnt, lat;
  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0; memRdata <= '0; lat <= 0; rdCnt <= 0; wrCnt <= 0;
      for (int i = 0; i < 4096; i++) extMem[i] <= seedVal(i);
    end else begin
      memAck <= 1'b0;
      if (memReq && !memAck) begin
        if (lat == 2) begin
          lat <= 0;
          memAck <= 1'b1;
          if (memWe) begin extMem[ix(memAddr)] <= memWdata; wrCnt <= wrCnt + 1; end
          else begin memRdata <= extMem[ix(memAddr)]; rdCnt <= rdCnt + 1; end
        end else lat <= lat + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = wd;
    waits = 0;
    #1;
    while (!cpuReady) begin @(negedge clk); #1; waits++; end
    rd = cpuRdata;
    @(posedge clk); #1;
    cpuValid = 1'b0; cpuWrite = 1'b0;
  endtask

  task automatic mnt(input logic [1:0] op, input logic [31:0] s, input logic [31:0] n);
    @(negedge clk);
    mntValid = 1'b1; mntOp = op; mntStart = s; mntCount = n;
    #1;
    while (!mntReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    mntValid = 1'b0;
    chk(!mntDone && !mntReady, "R12 busy after accept", {30'd0, mntDone, mntReady}, 32'd0);
    while (!mntDone) @(negedge clk);
  endtask

  // sequences of reads with expected traffic
  task automatic rdExp(input logic [31:0] a, input logic [31:0] exp, input int dRd,
                       input int dWr, input string req);
    logic [31:0] v; int w; int r0, w0;
    r0 = rdCnt; w0 = wrCnt;
    cpu(1'b0, a, '0, v, w);
    chk(v == exp, {req, " data"}, v, exp);
    chk(rdCnt - r0 == dRd && wrCnt - w0 == dWr, {req, " traffic rd/wr"},
        32'((rdCnt - r0) * 256 + (wrCnt - w0)), 32'(dRd * 256 + dWr));
  endtask

  task automatic wrExp(input logic [31:0] a, input logic [31:0] d, input int dRd,
                       input int dWr, input string req);
    logic [31:0] v; int w; int r0, w0;
    r0 = rdCnt; w0 = wrCnt;
    cpu(1'b1, a, d, v, w);
    chk(rdCnt - r0 == dRd && wrCnt - w0 == dWr, {req, " traffic rd/wr"},
        32'((rdCnt - r0) * 256 + (wrCnt - w0)), 32'(dRd * 256 + dWr));
  endtask

  logic [31:0] shadow [1024];

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] v; int w, r0, w0, bad;
    localparam logic [31:0] A = 32'h100, B = 32'h300, C = 32'h500, D = 32'h700,
                            E = 32'h900, F = 32'hB00, G = 32'hD00;
    void'($urandom(32'd2024));
    cacheMap[0] = 1'b1; cacheMap[1] = 1'b1; cacheMap[3] = 1'b1;
    repeat (3) @(negedge clk);
    chk(mntDone && !cpuReady && !memReq, "R1 reset outputs",
        {29'd0, mntDone, cpuReady, memReq}, 32'd4);
    rstN = 1'b1;

    // R1/R2: cold miss fills a whole line, then hits
    rdExp(A + 4, seedVal(ix(A + 4)), 32, 0, "R1 R2 cold miss");
    r0 = rdCnt;
    cpu(1'b0, A + 8, '0, v, w);
    chk(w == 0 && rdCnt == r0, "R2 hit in same cycle", 32'(w), 32'd0);
    chk(v == seedVal(ix(A + 8)), "R2 hit data", v, seedVal(ix(A + 8)));

    // R3: write hit stays on chip
    wrExp(A, 32'h1111_1111, 0, 0, "R3 write hit");
    chk(extMem[ix(A)] == seedVal(ix(A)), "R3 memory untouched", extMem[ix(A)], seedVal(ix(A)));
    rdExp(A, 32'h1111_1111, 0, 0, "R3 read back");

    // R4: invalid ways first, then LRU, dirty victim written back
    rdExp(B, seedVal(ix(B)), 32, 0, "R4 fill B");
    rdExp(C, seedVal(ix(C)), 32, 0, "R4 fill C");
    rdExp(D, seedVal(ix(D)), 32, 0, "R4 fill D");
    rdExp(A, 32'h1111_1111, 0, 0, "R4 touch A");
    rdExp(E, seedVal(ix(E)), 32, 0, "R4 E evicts clean LRU B");
    rdExp(A, 32'h1111_1111, 0, 0, "R4 A kept");
    rdExp(C, seedVal(ix(C)), 0, 0, "R4 C kept");
    rdExp(D, seedVal(ix(D)), 0, 0, "R4 D kept");
    rdExp(B, seedVal(ix(B)), 32, 0, "R4 B evicts E");
    rdExp(F, seedVal(ix(F)), 32, 32, "R4 F evicts dirty A");
    chk(extMem[ix(A)] == 32'h1111_1111, "R4 victim written back", extMem[ix(A)], 32'h1111_1111);

    // R5: freeze
    @(negedge clk); mode = 2'b01;
    rdExp(G, seedVal(ix(G)), 1, 0, "R5 freeze miss direct");
    rdExp(G, seedVal(ix(G)), 1, 0, "R5 freeze miss not allocated");
    rdExp(F, seedVal(ix(F)), 0, 0, "R5 freeze hit");
    wrExp(F + 4, 32'h2222_2222, 0, 0, "R5 freeze write hit");
    wrExp(G, 32'h5A5A_0001, 0, 1, "R5 freeze write miss");
    chk(extMem[ix(G)] == 32'h5A5A_0001, "R5 write miss to memory", extMem[ix(G)], 32'h5A5A_0001);
    rdExp(C, seedVal(ix(C)), 0, 0, "R5 no eviction happened");

    // R6: bypass
    @(negedge clk); mode = 2'b10;
    rdExp(F + 4, seedVal(ix(F + 4)), 1, 0, "R6 bypass reads memory");
    wrExp(F + 8, 32'h3333_3333, 0, 1, "R6 bypass write to memory");
    @(negedge clk); mode = 2'b00;
    rdExp(F + 8, seedVal(ix(F + 8)), 0, 0, "R6 cached line unchanged");
    rdExp(F + 4, 32'h2222_2222, 0, 0, "R6 dirty data kept");

    // R7: region not cacheable
    rdExp(32'h0200_0100, seedVal(ix(32'h0200_0100)), 1, 0, "R7 uncached read");
    rdExp(32'h0200_0100, seedVal(ix(32'h0200_0100)), 1, 0, "R7 uncached again");
    wrExp(32'h0200_0104, 32'h0BAD_0001, 0, 1, "R7 uncached write");

    // R8: invalidate discards dirty data
    wrExp(C, 32'h4444_4444, 0, 0, "R8 dirty C");
    w0 = wrCnt;
    mnt(2'b01, C + 4, 4);
    chk(wrCnt == w0, "R8 no writeback", 32'(wrCnt - w0), 32'd0);
    rdExp(C, seedVal(ix(C)), 32, 0, "R8 refetch after invalidate");

    // R9: writeback keeps line
    wrExp(D, 32'h5555_5555, 0, 0, "R9 dirty D");
    w0 = wrCnt;
    mnt(2'b10, D, 128);
    chk(wrCnt - w0 == 32, "R9 line written", 32'(wrCnt - w0), 32'd32);
    chk(extMem[ix(D)] == 32'h5555_5555, "R9 memory updated", extMem[ix(D)], 32'h5555_5555);
    rdExp(D, 32'h5555_5555, 0, 0, "R9 still resident");
    w0 = wrCnt;
    mnt(2'b10, D, 128);
    chk(wrCnt == w0, "R9 clean after writeback", 32'(wrCnt - w0), 32'd0);

    // R10: writeback then invalidate
    wrExp(B, 32'h6666_6666, 0, 0, "R10 dirty B");
    w0 = wrCnt;
    mnt(2'b11, B, 1);
    chk(wrCnt - w0 == 32, "R10 line written", 32'(wrCnt - w0), 32'd32);
    chk(extMem[ix(B)] == 32'h6666_6666, "R10 memory updated", extMem[ix(B)], 32'h6666_6666);
    rdExp(B, 32'h6666_6666, 32, 0, "R10 refetch after invalidate");

    // R11: partial range covers two lines, zero count covers none
    wrExp(32'h1000, 32'h7777_7777, 32, 0, "R11 dirty P");
    wrExp(32'h1080, 32'h8888_8888, 32, 0, "R11 dirty Q");
    w0 = wrCnt;
    mnt(2'b10, 32'h1064, 40);
    chk(wrCnt - w0 == 64, "R11 two lines written", 32'(wrCnt - w0), 32'd64);
    mnt(2'b01, 32'h1000, 0);
    rdExp(32'h1000, 32'h7777_7777, 0, 0, "R11 zero count no effect");

    // random mix of normal and freeze on region 1
    for (int i = 0; i < 1024; i++) shadow[i] = seedVal(1024 + i);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, d;
      int o;
      o = int'($urandom % 1024);
      a = 32'h0100_0000 + 32'(o * 4);
      @(negedge clk); mode = ($urandom % 4 == 0) ? 2'b01 : 2'b00;
      if ($urandom % 3 == 0) begin
        d = $urandom;
        cpu(1'b1, a, d, v, w);
        shadow[o] = d;
      end else begin
        cpu(1'b0, a, '0, v, w);
        chk(v == shadow[o], "R2 R3 R4 R5 random read", v, shadow[o]);
      end
    end
    @(negedge clk); mode = 2'b00;
    mnt(2'b10, 32'h0100_0000, 4096);
    bad = 0;
    for (int i = 0; i < 1024; i++) if (extMem[1024 + i] != shadow[i]) bad++;
    chk(bad == 0, "R9 random region flushed", 32'(bad), 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule